// File: doc/BRIEF.md
# ACPI SCI Event Generator

This block produces the level-sensitive system control interrupt (SCI) of an ACPI-style power-management unit. It holds three 16-bit registers:

- an event status register, whose bits are set by hardware and cleared by software;
- an event enable register;
- a general control register, which is plain storage here.

It also holds a free-running power-management timer. Event pulses from the power button, the RTC alarm, the global lock and a set of auxiliary sources set their status bits. The timer's own rollover event sets the timer status bit.

The interrupt line is a level. It is high while any of four interrupt-capable sources has both its status bit and its enable bit set. Status bits in other positions are kept and can be seen, but they never reach the interrupt.

The timer rollover event is armed only while the timer enable bit is set and the timer status bit is clear. A rollover that happens while it is not armed is lost; it does not wait until later.

Software uses a single-cycle write port to clear status bits, load the enable register and load the control register. All register contents are visible on output ports.

Top module: `sci_event_gen`

## Requirements
- R1: After reset the status, enable and control registers and the timer count are zero, and `sci` is low.
- R2: A high `ev_tmr` is not an input; the event inputs `ev_glock`, `ev_pwrbtn` and `ev_rtc` set status bits 5, 8 and 10, and `ev_aux[n]` sets status bit n. The bit appears on `pm1_sts` one cycle after the pulse, whatever the enable register holds.
- R3: A write with `wr_sel` = 0 clears every status bit whose `wr_data` bit is 1 and leaves the other status bits unchanged. If an event sets a bit in the same cycle that a write clears it, the set wins.
- R4: A write with `wr_sel` = 1 replaces the enable register and a write with `wr_sel` = 2 replaces the control register. A write with `wr_sel` = 3 changes no register.
- R5: `sci` equals the OR, over the bit positions 0 (timer), 5 (global lock), 8 (power button) and 10 (RTC), of status AND enable. It follows the registers combinationally, so it changes in the same cycle as they do.
- R6: Status and enable bits at any position other than 0, 5, 8 and 10 never drive `sci` high, even when both are set.
- R7: The timer count (`TMR_W` bits, 24 by default) increments by one in every cycle in which `tick` is high, wraps to zero, and holds otherwise.
- R8: A change of the top bit of the timer count sets status bit 0, but only if enable bit 0 is 1 and status bit 0 is 0 in that cycle. Otherwise the change has no effect.
- R9: Writing an enable bit for a source whose status bit is already set raises `sci` in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timer increment strobe |
| ev_pwrbtn | input | 1 | Power button event pulse (status bit 8) |
| ev_rtc | input | 1 | RTC alarm event pulse (status bit 10) |
| ev_glock | input | 1 | Global lock event pulse (status bit 5) |
| ev_aux | input | 16 | Other event pulses, bit n sets status bit n |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 status (clear), 1 enable, 2 control, 3 none |
| wr_data | input | 16 | Write data |
| pm1_sts | output | 16 | Event status register |
| pm1_en | output | 16 | Event enable register |
| pm1_ctl | output | 16 | Control register |
| tmr_count | output | TMR_W | Timer count |
| sci | output | 1 | System control interrupt level |

## Verification
The assertions treat event inputs and writes as already synchronous, single-cycle values that the block samples at the clock edge. The property for clearing a status bit only claims the bit ends low when no event for that same bit arrives in that cycle. The disarm property likewise excludes an auxiliary pulse on bit 0.

The stimulus drives every input on the falling edge and holds it for exactly one rising edge. It deliberately includes the one overlap the block has to resolve: a set and a clear of the same status bit in the same cycle.

The timer runs with a narrowed width so that its top bit changes several times within the run. It does so both with the timer event armed and with it disarmed.

// File: rtl/sci_pkg.sv
package sci_pkg;

    localparam int REG_W = 16;

    // Bit positions of the interrupt-capable sources (status and enable share them)
    localparam int POS_TMR = 0;
    localparam int POS_GLK = 5;
    localparam int POS_PWR = 8;
    localparam int POS_RTC = 10;

    localparam logic [REG_W-1:0] SCI_SRC_MASK =
        (REG_W'(1) << POS_TMR) | (REG_W'(1) << POS_GLK) |
        (REG_W'(1) << POS_PWR) | (REG_W'(1) << POS_RTC);

    typedef enum logic [1:0] {
        SEL_STS  = 2'd0,
        SEL_EN   = 2'd1,
        SEL_CTL  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    function automatic logic [REG_W-1:0] bit_at(input int pos, input logic v);
        bit_at = '0;
        bit_at[pos] = v;
    endfunction

endpackage

// File: rtl/pm_timer_ctr.sv
module pm_timer_ctr #(
    parameter int TMR_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    output logic [TMR_W-1:0] count,
    output logic             msb_flip
);
    localparam int MSB = TMR_W - 1;

    typedef struct packed {
        logic [TMR_W-1:0] cnt;
    } tmr_state_t;

    tmr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        msb_flip = st_d.cnt[MSB] ^ st_q.cnt[MSB];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count = st_q.cnt;

endmodule

// File: rtl/pm_evt_regs.sv
module pm_evt_regs
    import sci_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] set_vec,
    input  logic             wr_en,
    input  reg_sel_e         wr_sel,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] sts,
    output logic [REG_W-1:0] en,
    output logic [REG_W-1:0] ctl
);
    typedef struct packed {
        logic [REG_W-1:0] sts;
        logic [REG_W-1:0] en;
        logic [REG_W-1:0] ctl;
    } reg_state_t;

    reg_state_t st_d, st_q;
    logic [REG_W-1:0] clr_vec;

    always_comb begin
        st_d    = st_q;
        clr_vec = '0;
        if (wr_en) begin
            unique case (wr_sel)
                SEL_STS:  clr_vec  = wr_data;
                SEL_EN:   st_d.en  = wr_data;
                SEL_CTL:  st_d.ctl = wr_data;
                default:  ;
            endcase
        end
        // a new event in the same cycle outranks a software clear
        st_d.sts = (st_q.sts & ~clr_vec) | set_vec;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sts = st_q.sts;
    assign en  = st_q.en;
    assign ctl = st_q.ctl;

endmodule

// File: rtl/sci_level_eval.sv
module sci_level_eval
    import sci_pkg::*;
(
    input  logic [REG_W-1:0] sts,
    input  logic [REG_W-1:0] en,
    output logic             sci_lvl,
    output logic             tmr_armed
);
    logic [REG_W-1:0] hit;

    generate
        for (genvar i = 0; i < REG_W; i++) begin : g_src
            if (SCI_SRC_MASK[i]) begin : g_live
                assign hit[i] = sts[i] & en[i];
            end else begin : g_dead
                assign hit[i] = 1'b0;
            end
        end
    endgenerate

    always_comb begin
        sci_lvl   = |hit;
        tmr_armed = en[POS_TMR] & ~sts[POS_TMR];
    end

endmodule

// File: rtl/sci_event_gen.sv
module sci_event_gen
    import sci_pkg::*;
#(
    parameter int TMR_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             ev_pwrbtn,
    input  logic             ev_rtc,
    input  logic             ev_glock,
    input  logic [15:0]      ev_aux,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [15:0]      wr_data,
    output logic [15:0]      pm1_sts,
    output logic [15:0]      pm1_en,
    output logic [15:0]      pm1_ctl,
    output logic [TMR_W-1:0] tmr_count,
    output logic             sci
);
    logic             msb_flip;
    logic             tmr_armed;
    logic [REG_W-1:0] set_vec;
    reg_sel_e         sel;

    assign sel = reg_sel_e'(wr_sel);

    pm_timer_ctr #(.TMR_W(TMR_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .count    (tmr_count),
        .msb_flip (msb_flip)
    );

    always_comb begin
        set_vec = ev_aux
                | bit_at(POS_GLK, ev_glock)
                | bit_at(POS_PWR, ev_pwrbtn)
                | bit_at(POS_RTC, ev_rtc)
                | bit_at(POS_TMR, msb_flip & tmr_armed);
    end

    pm_evt_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .wr_en   (wr_en),
        .wr_sel  (sel),
        .wr_data (wr_data),
        .sts     (pm1_sts),
        .en      (pm1_en),
        .ctl     (pm1_ctl)
    );

    sci_level_eval u_lvl (
        .sts       (pm1_sts),
        .en        (pm1_en),
        .sci_lvl   (sci),
        .tmr_armed (tmr_armed)
    );

endmodule

// File: rtl/sci_event_gen_chk.sv
module sci_event_gen_chk #(
    parameter int TMR_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             ev_pwrbtn,
    input logic             ev_rtc,
    input logic [15:0]      ev_aux,
    input logic             wr_en,
    input logic [1:0]       wr_sel,
    input logic [15:0]      wr_data,
    input logic [15:0]      pm1_sts,
    input logic [15:0]      pm1_en,
    input logic [15:0]      pm1_ctl,
    input logic [TMR_W-1:0] tmr_count,
    input logic             sci
);
    localparam logic [15:0] LIVE = 16'h0521;

    a_r2_pwrbtn_sets: assert property (@(posedge clk) disable iff (!rst_n)
        ev_pwrbtn |=> pm1_sts[8]);

    a_r3_rtc_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd0 && wr_data[10] && !ev_rtc && !ev_aux[10]) |=> !pm1_sts[10]);

    a_r4_ctl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_sel == 2'd2) |=> $stable(pm1_ctl));

    a_r6_dead_bits: assert property (@(posedge clk) disable iff (!rst_n)
        ((pm1_sts & LIVE) == 16'h0) |-> !sci);

    a_r7_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (tmr_count == $past(tmr_count) + 1'b1));

    a_r7_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(tmr_count));

    a_r8_disarmed: assert property (@(posedge clk) disable iff (!rst_n)
        (!pm1_en[0] && !pm1_sts[0] && !ev_aux[0]) |=> !pm1_sts[0]);

    a_r9_late_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd1 && ((wr_data & pm1_sts & LIVE) != 16'h0)) |=> sci);

endmodule

bind sci_event_gen sci_event_gen_chk #(.TMR_W(TMR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .ev_pwrbtn (ev_pwrbtn),
    .ev_rtc    (ev_rtc),
    .ev_aux    (ev_aux),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .pm1_sts   (pm1_sts),
    .pm1_en    (pm1_en),
    .pm1_ctl   (pm1_ctl),
    .tmr_count (tmr_count),
    .sci       (sci)
);

// File: tb/tb_sci_event_gen.sv
module tb_sci_event_gen;
    localparam int TW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0;
    logic          ev_pwrbtn = 1'b0, ev_rtc = 1'b0, ev_glock = 1'b0;
    logic [15:0]   ev_aux = '0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_sel = 2'd0;
    logic [15:0]   wr_data = '0;
    logic [15:0]   pm1_sts, pm1_en, pm1_ctl;
    logic [TW-1:0] tmr_count;
    logic          sci;

    sci_event_gen #(.TMR_W(TW)) dut (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .ev_pwrbtn(ev_pwrbtn), .ev_rtc(ev_rtc), .ev_glock(ev_glock), .ev_aux(ev_aux),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .pm1_sts(pm1_sts), .pm1_en(pm1_en), .pm1_ctl(pm1_ctl),
        .tmr_count(tmr_count), .sci(sci)
    );

    always #4 clk = ~clk;

    typedef struct {
        logic          sci;
        logic [15:0]   sts, en, ctl;
        logic [TW-1:0] cnt;
        string         req;
    } exp_t;

    exp_t q[$];
    int   n_vec = 0;
    int   n_bad = 0;

    logic [15:0]   m_sts = '0, m_en = '0, m_ctl = '0;
    logic [TW-1:0] m_cnt = '0;

    localparam logic [15:0] LIVE = 16'h0521;  // bits 0, 5, 8, 10

    task automatic compare(input exp_t e);
        n_vec++;
        if (sci !== e.sci || pm1_sts !== e.sts || pm1_en !== e.en ||
            pm1_ctl !== e.ctl || tmr_count !== e.cnt) begin
            n_bad++;
            $display("FAIL %s: got sci=%b sts=%h en=%h ctl=%h cnt=%h, want sci=%b sts=%h en=%h ctl=%h cnt=%h",
                     e.req, sci, pm1_sts, pm1_en, pm1_ctl, tmr_count,
                     e.sci, e.sts, e.en, e.ctl, e.cnt);
        end
    endtask

    // monitor: pops one expectation after each edge that follows a driven vector
    always @(posedge clk) begin
        #2;
        if (q.size() > 0) compare(q.pop_front());
    end

    // driver: applies one cycle of stimulus and predicts the result
    task automatic step(input logic tk, input logic pb, input logic rt, input logic gl,
                        input logic [15:0] aux, input logic we, input logic [1:0] sel,
                        input logic [15:0] d, input string req);
        logic [TW-1:0] n_cnt;
        logic          flip, armed;
        logic [15:0]   setv, clrv;
        exp_t          e;
        @(negedge clk);
        tick = tk; ev_pwrbtn = pb; ev_rtc = rt; ev_glock = gl; ev_aux = aux;
        wr_en = we; wr_sel = sel; wr_data = d;
        n_cnt = tk ? m_cnt + 1'b1 : m_cnt;
        flip  = n_cnt[TW-1] != m_cnt[TW-1];
        armed = m_en[0] && !m_sts[0];
        setv  = aux;
        setv[5]  = setv[5]  | gl;
        setv[8]  = setv[8]  | pb;
        setv[10] = setv[10] | rt;
        setv[0]  = setv[0]  | (flip && armed);
        clrv  = (we && sel == 2'd0) ? d : 16'h0;
        m_sts = (m_sts & ~clrv) | setv;
        if (we && sel == 2'd1) m_en  = d;
        if (we && sel == 2'd2) m_ctl = d;
        m_cnt = n_cnt;
        e.sci = |(m_sts & m_en & LIVE);
        e.sts = m_sts; e.en = m_en; e.ctl = m_ctl; e.cnt = m_cnt; e.req = req;
        q.push_back(e);
    endtask

    task automatic idle(input string req);
        step(1'b0, 1'b0, 1'b0, 1'b0, 16'h0, 1'b0, 2'd0, 16'h0, req);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [15:0] d, input string req);
        step(1'b0, 1'b0, 1'b0, 1'b0, 16'h0, 1'b1, sel, d, req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got no completion, want completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        begin
            exp_t e;
            e.sci = 1'b0; e.sts = '0; e.en = '0; e.ctl = '0; e.cnt = '0; e.req = "R1";
            compare(e);
        end

        // R2: events set status with enable all zero
        step(1'b0, 1'b1, 1'b0, 1'b0, 16'h0, 1'b0, 2'd0, 16'h0, "R2 pwrbtn");
        step(1'b0, 1'b0, 1'b1, 1'b0, 16'h0, 1'b0, 2'd0, 16'h0, "R2 rtc");
        step(1'b0, 1'b0, 1'b0, 1'b1, 16'h0, 1'b0, 2'd0, 16'h0, "R2 glock");
        step(1'b0, 1'b0, 1'b0, 1'b0, 16'h8008, 1'b0, 2'd0, 16'h0, "R2 aux");
        idle("R2 hold");

        // R9 / R5: enable already-set sources
        wr(2'd1, 16'h0500, "R9 enable pwr+rtc");
        // R3: write-1-to-clear
        wr(2'd0, 16'h0100, "R3 clear pwr");
        wr(2'd0, 16'h0000, "R3 zero write");
        wr(2'd0, 16'h0400, "R3 clear rtc");
        // R3: set wins over clear in the same cycle
        step(1'b0, 1'b1, 1'b0, 1'b0, 16'h0, 1'b1, 2'd0, 16'h0100, "R3 set wins");
        wr(2'd0, 16'hFFFF, "R3 clear all");
        // R5: global lock path
        wr(2'd1, 16'h0020, "R5 enable glock");
        step(1'b0, 1'b0, 1'b0, 1'b1, 16'h0, 1'b0, 2'd0, 16'h0, "R5 glock raises sci");
        wr(2'd0, 16'h0020, "R5 glock clear");

        // R6: non-source bits never drive sci
        wr(2'd1, 16'hFADE, "R6 enable dead bits");
        step(1'b0, 1'b0, 1'b0, 1'b0, 16'hFADE, 1'b0, 2'd0, 16'h0, "R6 dead status");
        idle("R6 hold");
        wr(2'd0, 16'hFFFF, "R6 clear");

        // R4: control and no-target writes
        wr(2'd2, 16'h1234, "R4 ctl write");
        wr(2'd3, 16'hFFFF, "R4 sel3 no effect");
        idle("R4 hold");

        // R7 / R8: timer disarmed, then armed
        wr(2'd1, 16'h0000, "R8 disarm");
        for (int i = 0; i < 2100; i++) step(1'b1, 1'b0, 1'b0, 1'b0, 16'h0, 1'b0, 2'd0, 16'h0, "R8 disarmed R7");
        idle("R7 hold");
        wr(2'd1, 16'h0001, "R8 arm");
        for (int i = 0; i < 2100; i++) step(1'b1, 1'b0, 1'b0, 1'b0, 16'h0, 1'b0, 2'd0, 16'h0, "R8 armed R7");
        wr(2'd0, 16'h0001, "R8 clear timer");
        for (int i = 0; i < 2100; i++) step(1'b1, 1'b0, 1'b0, 1'b0, 16'h0, 1'b0, 2'd0, 16'h0, "R8 rearmed R7");
        idle("R8 end");
        repeat (3) @(negedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule